// File: doc/BRIEF.md
# Program Status and Identification Readback

This block forms the byte returned on each read of a page-programmed flash array and decides whether a program or whole-chip erase request may go ahead. While an internal program cycle is running, a read does not return array contents. It returns a status byte instead, which carries two separate end-of-cycle indicators. The first is the inverted top bit of the byte loaded last. The second is a bit that alternates on every read. In identification mode a read returns fixed identity codes, or a report on whether each boot region is locked. Otherwise the array data passes through.

Two boot regions are protected: the lowest 16 KB and the highest 16 KB of the 512 KB space. A program request aimed at a sector inside a locked region is dropped, so no grant is issued. A whole-chip erase is granted only while neither region is locked. The lock flags come from outside the block, which stores no lock state of its own.

Top module: `flash_status_readback`

## Requirements
- R1: Reset sets rdData to 00h. rdData changes only on the clock edge where rdStrobe is high and is visible in the following cycle. Without a strobe it holds its value, whatever the other inputs do.
- R2: A read taken while busy is high returns bit 7 equal to the inverse of bit 7 of lastByte, and bits 5..0 equal to zero.
- R3: In a status read, bit 6 is 0 on the first read of each busy period and inverts on every later read in the same period. Any cycle with busy low restarts the sequence.
- R4: A read with busy low and idMode low returns arrayData unchanged.
- R5: A read in identification mode (busy low) returns 1Fh at address 00000h and C4h at address 00001h. Any address without a defined code returns 00h.
- R6: A read in identification mode at address 00002h returns FFh when lockLo is high and FEh when it is low, whatever lockHi is.
- R7: A read in identification mode at address 7FFF2h returns FFh when lockHi is high and FEh when it is low.
- R8: busy takes precedence over idMode. A read while busy always returns the status byte.
- R9: pgmGrant equals pgmReq from the previous cycle, except that it is 0 when the sector index (address bits 18..8) lies in 0..63 while lockLo is high, or in 1984..2047 while lockHi is high.
- R10: eraseGrant equals eraseReq from the previous cycle while both lock flags are low, and is 0 whenever either flag was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| rdStrobe | input | 1 | One-cycle read event |
| addr | input | 19 | Byte address of the read |
| busy | input | 1 | Internal program cycle in progress |
| lastByte | input | 8 | Byte loaded last into the page buffer |
| idMode | input | 1 | Identification mode active |
| lockLo | input | 1 | Lower boot region locked |
| lockHi | input | 1 | Upper boot region locked |
| arrayData | input | 8 | Data read from the array |
| pgmReq | input | 1 | Request to start a sector program |
| pgmSector | input | 11 | Sector index of the program request |
| eraseReq | input | 1 | Request to start a whole-chip erase |
| rdData | output | 8 | Read byte presented to the bus |
| pgmGrant | output | 1 | Program request accepted |
| eraseGrant | output | 1 | Chip erase accepted |

## Verification
Every result in this block passes through exactly one register. The read byte is due in the cycle after the strobed edge, and both grants are due in the cycle after the request. The bench drives inputs on the falling edge and samples them on the next falling edge, so each check sees the result of the single rising edge in between. The alternating status bit is checked over several back-to-back reads and again after a one-cycle idle gap that starts a new busy period.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [7:0] MFR_CODE  = 8'h1F;
  localparam logic [7:0] DEV_CODE  = 8'hC4;
  localparam logic [7:0] LOCK_OPEN = 8'hFE;
  localparam logic [7:0] LOCK_SET  = 8'hFF;

  typedef struct packed {
    logic loadStatus;
    logic loadId;
    logic loadArray;
    logic togFlip;
    logic togClr;
  } rdStrobes_t;
endpackage

// File: rtl/fsr_read_ctrl.sv
module fsr_read_ctrl
  import fsr_pkg::*;
(
  input  logic       rdStrobe,
  input  logic       busy,
  input  logic       idMode,
  output rdStrobes_t strb
);
  always_comb begin
    strb.loadStatus = rdStrobe && busy;
    strb.loadId     = rdStrobe && !busy && idMode;
    strb.loadArray  = rdStrobe && !busy && !idMode;
    strb.togFlip    = rdStrobe && busy;
    strb.togClr     = !busy;
  end
endmodule

// File: rtl/fsr_read_dp.sv
module fsr_read_dp
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              lockLo,
  input  logic              lockHi,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] ID_MFR_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_DEV_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_LO_ADDR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ID_HI_ADDR  = {{(ADDR_W-4){1'b1}}, 4'h2};

  logic              togState;
  logic [DATA_W-1:0] idByte;
  logic [DATA_W-1:0] statusByte;

  always_comb begin
    unique case (addr)
      ID_MFR_ADDR: idByte = MFR_CODE;
      ID_DEV_ADDR: idByte = DEV_CODE;
      ID_LO_ADDR:  idByte = lockLo ? LOCK_SET : LOCK_OPEN;
      ID_HI_ADDR:  idByte = lockHi ? LOCK_SET : LOCK_OPEN;
      default:     idByte = '0;
    endcase
  end

  always_comb begin
    statusByte = '0;
    statusByte[DATA_W-1] = ~lastByte[DATA_W-1];
    statusByte[DATA_W-2] = togState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togState <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strb.togClr)       togState <= 1'b0;
      else if (strb.togFlip) togState <= ~togState;

      if (strb.loadStatus)     rdData <= statusByte;
      else if (strb.loadId)    rdData <= idByte;
      else if (strb.loadArray) rdData <= arrayData;
    end
  end
endmodule

// File: rtl/fsr_lock_gate.sv
module fsr_lock_gate #(
  parameter int ADDR_W = 19,
  parameter int PAGE_W = 8,
  parameter int BOOT_W = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pgmReq,
  input  logic [ADDR_W-PAGE_W-1:0] pgmSector,
  input  logic                     eraseReq,
  input  logic                     lockLo,
  input  logic                     lockHi,
  output logic                     pgmGrant,
  output logic                     eraseGrant
);
  localparam int SEC_W = ADDR_W - PAGE_W;
  localparam int REG_W = BOOT_W - PAGE_W;

  logic [SEC_W-REG_W-1:0] regionTag;
  logic inLo, inHi, blocked;

  always_comb begin
    regionTag = pgmSector[SEC_W-1:REG_W];
    inLo      = (regionTag == '0);
    inHi      = &regionTag;
    blocked   = (inLo && lockLo) || (inHi && lockHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmGrant   <= 1'b0;
      eraseGrant <= 1'b0;
    end else begin
      pgmGrant   <= pgmReq && !blocked;
      eraseGrant <= eraseReq && !lockLo && !lockHi;
    end
  end
endmodule

// File: rtl/flash_status_readback.sv
module flash_status_readback
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter int BOOT_W = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdStrobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     busy,
  input  logic [DATA_W-1:0]        lastByte,
  input  logic                     idMode,
  input  logic                     lockLo,
  input  logic                     lockHi,
  input  logic [DATA_W-1:0]        arrayData,
  input  logic                     pgmReq,
  input  logic [ADDR_W-PAGE_W-1:0] pgmSector,
  input  logic                     eraseReq,
  output logic [DATA_W-1:0]        rdData,
  output logic                     pgmGrant,
  output logic                     eraseGrant
);
  rdStrobes_t strb;

  fsr_read_ctrl u_ctrl (
    .rdStrobe (rdStrobe),
    .busy     (busy),
    .idMode   (idMode),
    .strb     (strb)
  );

  fsr_read_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .lastByte  (lastByte),
    .arrayData (arrayData),
    .lockLo    (lockLo),
    .lockHi    (lockHi),
    .rdData    (rdData)
  );

  fsr_lock_gate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BOOT_W(BOOT_W)) u_gate (
    .clk        (clk),
    .rstN       (rstN),
    .pgmReq     (pgmReq),
    .pgmSector  (pgmSector),
    .eraseReq   (eraseReq),
    .lockLo     (lockLo),
    .lockHi     (lockHi),
    .pgmGrant   (pgmGrant),
    .eraseGrant (eraseGrant)
  );
endmodule

// File: rtl/flash_status_readback_chk.sv
module flash_status_readback_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     rdStrobe,
  input logic [ADDR_W-1:0]        addr,
  input logic                     busy,
  input logic [DATA_W-1:0]        lastByte,
  input logic                     idMode,
  input logic                     lockLo,
  input logic                     lockHi,
  input logic [DATA_W-1:0]        arrayData,
  input logic                     pgmReq,
  input logic [ADDR_W-PAGE_W-1:0] pgmSector,
  input logic                     eraseReq,
  input logic [DATA_W-1:0]        rdData,
  input logic                     pgmGrant,
  input logic                     eraseGrant
);
  a_r1_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));

  a_r2_status_inverted_top: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy) |=> (rdData[DATA_W-1] == ~$past(lastByte[DATA_W-1])) && (rdData[DATA_W-3:0] == '0));

  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy && $past(rdStrobe && busy)) |=> rdData[DATA_W-2] != $past(rdData[DATA_W-2]));

  a_r4_array_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !busy && !idMode) |=> rdData == $past(arrayData));

  a_r5_mfr_code: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !busy && idMode && addr == '0) |=> rdData == 8'h1F);

  a_r9_lower_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (lockLo && pgmSector[ADDR_W-PAGE_W-1:6] == '0) |=> !pgmGrant);

  a_r9_upper_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (lockHi && (&pgmSector[ADDR_W-PAGE_W-1:6])) |=> !pgmGrant);

  a_r10_erase_locked: assert property (@(posedge clk) disable iff (!rstN)
    (lockLo || lockHi) |=> !eraseGrant);
endmodule

bind flash_status_readback flash_status_readback_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/flash_status_readback_tb.sv
module flash_status_readback_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [18:0] addr = '0;
  logic        busy = 1'b0;
  logic [7:0]  lastByte = '0;
  logic        idMode = 1'b0;
  logic        lockLo = 1'b0;
  logic        lockHi = 1'b0;
  logic [7:0]  arrayData = '0;
  logic        pgmReq = 1'b0;
  logic [10:0] pgmSector = '0;
  logic        eraseReq = 1'b0;
  logic [7:0]  rdData;
  logic        pgmGrant;
  logic        eraseGrant;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flash_status_readback u_dut (.*);

  // fields: busy, idMode, lockLo, lockHi, addr[19], lastByte, arrayData, expected
  localparam int NV = 13;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 19'h12345, 8'h00, 8'hA5, 8'hA5},  // R4
    {1'b0, 1'b0, 1'b1, 1'b1, 19'h00002, 8'h00, 8'h3C, 8'h3C},  // R4
    {1'b0, 1'b1, 1'b0, 1'b0, 19'h00000, 8'h00, 8'h77, 8'h1F},  // R5
    {1'b0, 1'b1, 1'b0, 1'b0, 19'h00001, 8'h00, 8'h77, 8'hC4},  // R5
    {1'b0, 1'b1, 1'b0, 1'b0, 19'h00003, 8'h00, 8'h77, 8'h00},  // R5
    {1'b0, 1'b1, 1'b0, 1'b0, 19'h00002, 8'h00, 8'h77, 8'hFE},  // R6
    {1'b0, 1'b1, 1'b1, 1'b0, 19'h00002, 8'h00, 8'h77, 8'hFF},  // R6
    {1'b0, 1'b1, 1'b0, 1'b1, 19'h00002, 8'h00, 8'h77, 8'hFE},  // R6
    {1'b0, 1'b1, 1'b0, 1'b0, 19'h7FFF2, 8'h00, 8'h77, 8'hFE},  // R7
    {1'b0, 1'b1, 1'b0, 1'b1, 19'h7FFF2, 8'h00, 8'h77, 8'hFF},  // R7
    {1'b1, 1'b0, 1'b0, 1'b0, 19'h00100, 8'h5A, 8'hFF, 8'h80},  // R2
    {1'b1, 1'b0, 1'b0, 1'b0, 19'h00100, 8'hBF, 8'h00, 8'h00},  // R2
    {1'b1, 1'b1, 1'b0, 1'b0, 19'h00000, 8'h3F, 8'h1F, 8'h80}   // R8
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [18:0] a);
    @(negedge clk);
    addr = a;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic checkPgm(input string req, input logic [10:0] sec, input logic lo,
                          input logic hi, input logic exp);
    @(negedge clk);
    pgmSector = sec; lockLo = lo; lockHi = hi; pgmReq = 1'b1;
    @(negedge clk);
    pgmReq = 1'b0;
    check8(req, {7'b0, pgmGrant}, {7'b0, exp});
  endtask

  task automatic checkErase(input string req, input logic lo, input logic hi, input logic exp);
    @(negedge clk);
    lockLo = lo; lockHi = hi; eraseReq = 1'b1;
    @(negedge clk);
    eraseReq = 1'b0;
    check8(req, {7'b0, eraseGrant}, {7'b0, exp});
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    arrayData = 8'h99;
    repeat (3) @(negedge clk);
    check8("R1 reset value", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busy = 1'b0;
      @(negedge clk);
      busy = VEC[i][46]; idMode = VEC[i][45]; lockLo = VEC[i][44]; lockHi = VEC[i][43];
      lastByte = VEC[i][23:16]; arrayData = VEC[i][15:8];
      doRead(VEC[i][42:24]);
      check8($sformatf("R2/R4-R8 vector %0d", i), rdData, VEC[i][7:0]);
    end

    // R1: no strobe, inputs move, output holds
    busy = 1'b0; idMode = 1'b0; arrayData = 8'h42;
    doRead(19'h00010);
    arrayData = 8'hE7; idMode = 1'b1; addr = 19'h00000;
    repeat (3) @(negedge clk);
    check8("R1 hold without read", rdData, 8'h42);

    // R3: toggle sequence within a busy period
    idMode = 1'b0; lastByte = 8'h00; busy = 1'b1;
    for (int k = 0; k < 4; k++) begin
      doRead(19'h00200);
      check8("R3 toggle sequence", rdData, {1'b1, k[0], 6'b0});
    end
    // R3: back-to-back strobes
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    check8("R3 back-to-back first", rdData, 8'h80);
    @(negedge clk);
    rdStrobe = 1'b0;
    check8("R3 back-to-back second", rdData, 8'hC0);
    // R3: new busy period restarts at 0
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1;
    doRead(19'h00200);
    check8("R3 restart after idle", rdData, 8'h80);
    // R4: true data once busy ends
    busy = 1'b0; arrayData = 8'h6D;
    doRead(19'h00200);
    check8("R4 data after busy", rdData, 8'h6D);

    // R9 program gating
    checkPgm("R9 sector 0 lower locked", 11'd0, 1'b1, 1'b0, 1'b0);
    checkPgm("R9 sector 63 lower locked", 11'd63, 1'b1, 1'b0, 1'b0);
    checkPgm("R9 sector 64 both locked", 11'd64, 1'b1, 1'b1, 1'b1);
    checkPgm("R9 sector 1983 upper locked", 11'd1983, 1'b1, 1'b1, 1'b1);
    checkPgm("R9 sector 1984 upper locked", 11'd1984, 1'b0, 1'b1, 1'b0);
    checkPgm("R9 sector 2047 lower only", 11'd2047, 1'b1, 1'b0, 1'b1);
    checkPgm("R9 sector 0 unlocked", 11'd0, 1'b0, 1'b0, 1'b1);

    // R10 erase gating
    checkErase("R10 erase no locks", 1'b0, 1'b0, 1'b1);
    checkErase("R10 erase lower locked", 1'b1, 1'b0, 1'b0);
    checkErase("R10 erase upper locked", 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule